// File: doc/BRIEF.md
# Auto-Increment Gamma Lookup Table

This block applies per-channel gamma correction to up to three pixel streams. Each channel owns three sub-tables, one each for red, green and blue, and each sub-table holds 256 eight-bit entries. Software loads the tables through a small register port with two registers. The index register sets the next table position and an auto-increment flag. The data register stores one entry per write.

In the pixel path, each channel's red, green and blue components are looked up in parallel in that channel's own sub-tables. The results come out one clock later, with valid and sync delayed by the same clock. When a channel's gamma enable is clear, its components pass through unchanged. When every enable is clear at once, the table storage is treated as powered down. It forgets its contents and ignores data writes, so software must reload it after re-enabling.

Top module: `gamma_lut_top`

## Requirements
- R1: Table entry k (0..255) of channel ch, color c (0 red, 1 green, 2 blue) has global index (ch*3 + c)*256 + k. A pixel component of value k on channel ch, color c uses that entry. Components are packed per channel in pix_in_rgb[ch*24 +: 24] as red [23:16], green [15:8], blue [7:0], and pix_out_rgb uses the same packing.
- R2: A write with bus_sel=0 loads the index from bus_wdata[11:0] and the auto-increment flag from bus_wdata[31]. An index of 2304 or above is loaded as 0.
- R3: A write with bus_sel=1 stores bus_wdata[7:0] at the current index. If the auto-increment flag is set, the write then advances the index by one. The other data bits are ignored.
- R4: With the auto-increment flag clear, data writes leave the index unchanged, so repeated writes overwrite the same entry.
- R5: An auto-increment data write at index 2303 moves the index to 0.
- R6: With a channel's gamma enable set, each output component equals its table entry. The output appears one clock after the input, and pix_out_valid and pix_out_sync follow the inputs by that same clock.
- R7: With a channel's gamma enable clear, that channel's output components equal its input components one clock later.
- R8: While all gamma enables are clear, every entry is lost and afterwards reads as 0 until rewritten. Data writes made during that time are discarded, but the index still follows R3 to R5.
- R9: A data write and a pixel lookup of the same entry in the same cycle give the pixel path the entry's old value.
- R10: After reset, the outputs, valid and sync are 0, the index is 0, auto-increment is clear, and every entry reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 1 | 0 = index register, 1 = data register |
| bus_wdata | input | 32 | Register write data |
| gamma_en | input | 3 | Per-channel gamma enable |
| pix_in_valid | input | 3 | Per-channel input pixel valid |
| pix_in_sync | input | 3 | Per-channel input sync marker |
| pix_in_rgb | input | 72 | Per-channel input components, 24 bits each |
| pix_out_valid | output | 3 | Per-channel output pixel valid |
| pix_out_sync | output | 3 | Per-channel output sync marker |
| pix_out_rgb | output | 72 | Per-channel corrected components |

## Verification
Register writes take effect at the clock edge that samples them, so a lookup driven in the following cycle already sees the new entry or index. The exception is a lookup in the same cycle as the write, which must still see the old value. Every pixel result is due exactly one clock after its input is sampled. The driver builds the expected item from its own table model at the moment it drives the pixel, and queues it just after that edge. The monitor pops the item at the next falling edge, so each comparison lands in the cycle where the registered output is valid. Cycles with nothing queued must show no valid output.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;

  localparam int unsigned NUM_COLORS = 3;

  // first global index of the sub-table for channel ch, color col
  function automatic int unsigned sub_base(int unsigned ch, int unsigned col,
                                           int unsigned entries);
    return (ch * NUM_COLORS + col) * entries;
  endfunction

  // index after an auto-increment step, wrapping at the table end
  function automatic int unsigned step_index(int unsigned idx, int unsigned total);
    return (idx == total - 1) ? 0 : idx + 1;
  endfunction

  // index field as loaded from the bus, out-of-range values become 0
  function automatic int unsigned load_index(int unsigned field, int unsigned total);
    return (field < total) ? field : 0;
  endfunction

endpackage

// File: rtl/gamma_addr_ctrl.sv
module gamma_addr_ctrl
  import gamma_lut_pkg::*;
#(
  parameter int unsigned IDX_W = 12,
  parameter int unsigned TOTAL = 2304
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic             bus_sel,
  input  logic [IDX_W-1:0] idx_field,
  input  logic             ainc_field,
  output logic             data_wr,
  output logic [IDX_W-1:0] cur_idx
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(TOTAL - 1);

  logic             index_wr;
  logic [IDX_W-1:0] idx_q;
  logic             ainc_q;

  assign index_wr = bus_we && !bus_sel;
  assign data_wr  = bus_we && bus_sel;
  assign cur_idx  = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      ainc_q <= 1'b0;
    end else if (index_wr) begin
      idx_q  <= IDX_W'(load_index(32'(idx_field), TOTAL));
      ainc_q <= ainc_field;
    end else if (data_wr && ainc_q) begin
      idx_q  <= IDX_W'(step_index(32'(idx_q), TOTAL));
    end
  end

  a_r2_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST);

  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && ainc_q && idx_q != LAST) |=> (idx_q == $past(idx_q) + 1'b1));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !ainc_q) |=> $stable(idx_q));

  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && ainc_q && idx_q == LAST) |=> (idx_q == '0));

endmodule

// File: rtl/gamma_subtable.sv
module gamma_subtable #(
  parameter int unsigned ENTRIES = 256,
  parameter int unsigned PIX_W   = 8,
  localparam int unsigned ENT_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             power_down,
  input  logic             wr_en,
  input  logic [ENT_W-1:0] wr_ent,
  input  logic [PIX_W-1:0] wr_data,
  input  logic [ENT_W-1:0] rd_ent,
  output logic [PIX_W-1:0] rd_data
);

  logic [PIX_W-1:0]   mem [ENTRIES];
  logic [ENTRIES-1:0] live_q;
  logic [PIX_W-1:0]   rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ent] <= wr_data;
  end

  // an entry holds data only once written since the last power-down
  always_ff @(posedge clk) begin
    if (!rst_n)          live_q <= '0;
    else if (power_down) live_q <= '0;
    else if (wr_en)      live_q[wr_ent] <= 1'b1;
  end

  // registered read: a same-cycle write is not yet visible here
  always_ff @(posedge clk) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= live_q[rd_ent] ? mem[rd_ent] : '0;
  end

  assign rd_data = rd_q;

  a_r8_contents_lost: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |=> (live_q == '0));

  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !power_down) |=> live_q[$past(wr_ent)]);

endmodule

// File: rtl/gamma_chan_pipe.sv
module gamma_chan_pipe
  import gamma_lut_pkg::*;
#(
  parameter int unsigned CH      = 0,
  parameter int unsigned ENTRIES = 256,
  parameter int unsigned PIX_W   = 8,
  parameter int unsigned IDX_W   = 12,
  localparam int unsigned ENT_W  = $clog2(ENTRIES),
  localparam int unsigned RGB_W  = NUM_COLORS * PIX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  power_down,
  input  logic                  gamma_en,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [PIX_W-1:0]      wr_data,
  input  logic                  in_valid,
  input  logic                  in_sync,
  input  logic [RGB_W-1:0]      in_rgb,
  output logic                  out_valid,
  output logic                  out_sync,
  output logic [RGB_W-1:0]      out_rgb,
  output logic [NUM_COLORS-1:0] wr_hit
);

  logic             valid_q, sync_q, en_q;
  logic [RGB_W-1:0] rgb_q;
  logic [RGB_W-1:0] lut_rgb;

  for (genvar col = 0; col < NUM_COLORS; col++) begin : g_col
    localparam int unsigned BASE = sub_base(CH, col, ENTRIES);
    // red sits in the top field, blue in the bottom one
    localparam int unsigned POS  = (NUM_COLORS - 1 - col) * PIX_W;

    logic [ENT_W-1:0] ent;

    assign wr_hit[col] = wr_en && (32'(wr_idx) >= BASE) && (32'(wr_idx) < BASE + ENTRIES);
    assign ent         = ENT_W'(32'(wr_idx) - BASE);

    gamma_subtable #(.ENTRIES(ENTRIES), .PIX_W(PIX_W)) u_tab (
      .clk       (clk),
      .rst_n     (rst_n),
      .power_down(power_down),
      .wr_en     (wr_hit[col]),
      .wr_ent    (ent),
      .wr_data   (wr_data),
      .rd_ent    (in_rgb[POS +: ENT_W]),
      .rd_data   (lut_rgb[POS +: PIX_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      sync_q  <= 1'b0;
      en_q    <= 1'b0;
      rgb_q   <= '0;
    end else begin
      valid_q <= in_valid;
      sync_q  <= in_sync;
      en_q    <= gamma_en;
      rgb_q   <= in_rgb;
    end
  end

  assign out_valid = valid_q;
  assign out_sync  = sync_q;
  assign out_rgb   = en_q ? lut_rgb : rgb_q;

  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r6_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r6_sync_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_sync |=> out_sync);

  a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !gamma_en) |=> (out_rgb == $past(in_rgb)));

endmodule

// File: rtl/gamma_lut_top.sv
module gamma_lut_top
  import gamma_lut_pkg::*;
#(
  parameter int unsigned NUM_CH   = 3,
  parameter int unsigned ENTRIES  = 256,
  parameter int unsigned PIX_W    = 8,
  parameter int unsigned AINC_BIT = 31,
  localparam int unsigned TOTAL   = NUM_CH * NUM_COLORS * ENTRIES,
  localparam int unsigned IDX_W   = $clog2(TOTAL),
  localparam int unsigned RGB_W   = NUM_COLORS * PIX_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_we,
  input  logic                    bus_sel,
  input  logic [31:0]             bus_wdata,
  input  logic [NUM_CH-1:0]       gamma_en,
  input  logic [NUM_CH-1:0]       pix_in_valid,
  input  logic [NUM_CH-1:0]       pix_in_sync,
  input  logic [NUM_CH*RGB_W-1:0] pix_in_rgb,
  output logic [NUM_CH-1:0]       pix_out_valid,
  output logic [NUM_CH-1:0]       pix_out_sync,
  output logic [NUM_CH*RGB_W-1:0] pix_out_rgb
);

  logic                         data_wr;
  logic [IDX_W-1:0]             cur_idx;
  logic                         power_down;
  logic                         table_wr;
  logic [NUM_CH*NUM_COLORS-1:0] all_hits;
  logic                         unused_wdata;

  assign power_down   = ~|gamma_en;
  assign table_wr     = data_wr && !power_down;
  assign unused_wdata = ^bus_wdata;

  gamma_addr_ctrl #(.IDX_W(IDX_W), .TOTAL(TOTAL)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_sel   (bus_sel),
    .idx_field (bus_wdata[IDX_W-1:0]),
    .ainc_field(bus_wdata[AINC_BIT]),
    .data_wr   (data_wr),
    .cur_idx   (cur_idx)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    gamma_chan_pipe #(
      .CH(ch), .ENTRIES(ENTRIES), .PIX_W(PIX_W), .IDX_W(IDX_W)
    ) u_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .power_down(power_down),
      .gamma_en  (gamma_en[ch]),
      .wr_en     (table_wr),
      .wr_idx    (cur_idx),
      .wr_data   (bus_wdata[PIX_W-1:0]),
      .in_valid  (pix_in_valid[ch]),
      .in_sync   (pix_in_sync[ch]),
      .in_rgb    (pix_in_rgb[ch*RGB_W +: RGB_W]),
      .out_valid (pix_out_valid[ch]),
      .out_sync  (pix_out_sync[ch]),
      .out_rgb   (pix_out_rgb[ch*RGB_W +: RGB_W]),
      .wr_hit    (all_hits[ch*NUM_COLORS +: NUM_COLORS])
    );
  end

  a_r1_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(all_hits));

  a_r1_write_hits: assert property (@(posedge clk) disable iff (!rst_n)
    table_wr |-> ($countones(all_hits) == 1));

  a_r8_no_write_when_down: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |-> (all_hits == '0));

endmodule

// File: tb/sim_gamma_lut_top.sv
module sim_gamma_lut_top;

  localparam int CLK_PERIOD = 10;
  localparam int TOTAL      = 2304;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_sel = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [2:0]  gamma_en = '0;
  logic [2:0]  pix_in_valid = '0;
  logic [2:0]  pix_in_sync = '0;
  logic [71:0] pix_in_rgb = '0;
  logic [2:0]  pix_out_valid;
  logic [2:0]  pix_out_sync;
  logic [71:0] pix_out_rgb;

  always #(CLK_PERIOD/2) clk = ~clk;

  gamma_lut_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .gamma_en(gamma_en),
    .pix_in_valid(pix_in_valid), .pix_in_sync(pix_in_sync), .pix_in_rgb(pix_in_rgb),
    .pix_out_valid(pix_out_valid), .pix_out_sync(pix_out_sync), .pix_out_rgb(pix_out_rgb)
  );

  typedef struct {
    logic [2:0]  v;
    logic [2:0]  s;
    logic [71:0] rgb;
    string       tag;
  } exp_t;

  exp_t       sb[$];
  int         checks = 0;
  int         fails = 0;
  bit         mon_on = 0;
  logic [7:0] mdl [TOTAL];
  int         bidx = 0;
  bit         bainc = 0;

  task automatic check(input bit ok, input string tag, input logic [71:0] act,
                       input logic [71:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench model of one component lookup
  function automatic logic [7:0] model_comp(int ch, int col, logic [7:0] k);
    if (!gamma_en[ch]) return k;
    return mdl[(ch*3 + col)*256 + int'(k)];
  endfunction

  function automatic logic [71:0] model_rgb(logic [71:0] in);
    logic [71:0] r;
    for (int ch = 0; ch < 3; ch++)
      for (int col = 0; col < 3; col++)
        r[ch*24 + (2-col)*8 +: 8] = model_comp(ch, col, in[ch*24 + (2-col)*8 +: 8]);
    return r;
  endfunction

  function automatic logic [71:0] pack3(logic [23:0] c0, logic [23:0] c1, logic [23:0] c2);
    return {c2, c1, c0};
  endfunction

  // one bus/pixel cycle; expected item built from the model before the write
  task automatic cyc(input bit do_pix, input logic [2:0] v, input logic [2:0] s,
                     input logic [71:0] rgb, input bit do_wr, input bit sel,
                     input logic [31:0] wd, input string tag);
    exp_t e;
    @(negedge clk);
    bus_we = do_wr; bus_sel = sel; bus_wdata = wd;
    pix_in_valid = do_pix ? v : 3'b000;
    pix_in_sync  = do_pix ? s : 3'b000;
    pix_in_rgb   = rgb;
    e.v = pix_in_valid; e.s = pix_in_sync; e.rgb = model_rgb(rgb); e.tag = tag;
    if (do_wr && !sel) begin
      bidx  = (int'(wd[11:0]) < TOTAL) ? int'(wd[11:0]) : 0;
      bainc = wd[31];
    end else if (do_wr && sel) begin
      if (gamma_en != 3'b000) mdl[bidx] = wd[7:0];
      if (bainc) bidx = (bidx == TOTAL-1) ? 0 : bidx + 1;
    end
    @(posedge clk);
    if (do_pix) sb.push_back(e);
  endtask

  task automatic set_index(input int idx, input bit ainc);
    cyc(0, 3'b0, 3'b0, '0, 1, 0, {ainc, 19'd0, 12'(idx)}, "R2");
  endtask

  task automatic put(input logic [7:0] d, input logic [23:0] junk);
    cyc(0, 3'b0, 3'b0, '0, 1, 1, {junk, d}, "R3");
  endtask

  task automatic pix(input logic [2:0] v, input logic [2:0] s, input logic [71:0] rgb,
                     input string tag);
    cyc(1, v, s, rgb, 0, 0, '0, tag);
  endtask

  task automatic set_en(input logic [2:0] en);
    @(negedge clk);
    bus_we = 0; pix_in_valid = '0; pix_in_sync = '0;
    gamma_en = en;
    if (en == 3'b000) for (int i = 0; i < TOTAL; i++) mdl[i] = 8'h00;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 3'b0, 3'b0, '0, 0, 0, '0, "idle");
  endtask

  // monitor: an item pushed after edge t is due at the falling edge after t
  always @(negedge clk) begin
    if (mon_on) begin
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(pix_out_valid == e.v && pix_out_sync == e.s,
              {e.tag, " R6 valid/sync"}, {66'd0, pix_out_valid, pix_out_sync},
              {66'd0, e.v, e.s});
        for (int ch = 0; ch < 3; ch++)
          if (e.v[ch])
            check(pix_out_rgb[ch*24 +: 24] == e.rgb[ch*24 +: 24],
                  $sformatf("%s ch%0d rgb", e.tag, ch),
                  {48'd0, pix_out_rgb[ch*24 +: 24]}, {48'd0, e.rgb[ch*24 +: 24]});
      end else begin
        check(pix_out_valid == 3'b000, "R6 idle valid", {69'd0, pix_out_valid}, 72'd0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < TOTAL; i++) mdl[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pix_out_valid == 0 && pix_out_sync == 0 && pix_out_rgb == 0,
          "R10 reset outputs", pix_out_rgb, 72'd0);
    rst_n = 1'b1;
    mon_on = 1;
    set_en(3'b111);

    // R10: empty table reads 0, index starts at 0 without auto-increment
    pix(3'b111, 3'b001, pack3(24'h050607, 24'h80FF01, 24'h7F0010), "R10 empty table");
    put(8'h3C, 24'h000000);
    put(8'h3D, 24'h000000);
    pix(3'b001, 3'b000, pack3(24'h000000, 24'h0, 24'h0), "R10 index 0 no advance");

    // R1 R3: fill the whole table with junk in the upper data bits
    set_index(0, 1);
    for (int i = 0; i < TOTAL; i++) put(8'((i*37 + (i >> 8)*11 + 5)), 24'hC30000 | 24'(i));
    pix(3'b111, 3'b010, pack3(24'h000102, 24'hFF8040, 24'h10EEA5), "R1 R6 lookup a");
    pix(3'b111, 3'b100, pack3(24'hFFFFFF, 24'h000000, 24'h7F8081), "R1 R6 lookup b");
    pix(3'b101, 3'b001, pack3(24'h123456, 24'h9ABCDE, 24'hF00D42), "R1 R6 lookup c");
    pix(3'b010, 3'b010, pack3(24'h0, 24'h11EE22, 24'h0), "R1 R6 lookup d");

    // R7: bypass on channels 0 and 2
    set_en(3'b010);
    pix(3'b111, 3'b111, pack3(24'hA1B2C3, 24'h010203, 24'h5A6B7C), "R7 bypass");
    pix(3'b101, 3'b000, pack3(24'hFF00FF, 24'h0, 24'h00FF00), "R7 bypass b");
    set_en(3'b111);

    // R4: no auto-increment, repeated writes hit one entry (ch0 green 44)
    set_index(300, 0);
    put(8'h11, 24'h0);
    put(8'h22, 24'h0);
    pix(3'b001, 3'b000, pack3(24'h002C00, 24'h0, 24'h0), "R4 same entry");
    pix(3'b001, 3'b000, pack3(24'h002D00, 24'h0, 24'h0), "R4 neighbour kept");

    // R5: wrap from 2303 (ch2 blue 255) to 0 (ch0 red 0)
    set_index(2303, 1);
    put(8'hAB, 24'h0);
    put(8'hCD, 24'h0);
    pix(3'b101, 3'b000, pack3(24'h000000, 24'h0, 24'h0000FF), "R5 wrap");

    // R2: out-of-range index loads as 0
    set_index(3000, 1);
    put(8'h77, 24'h0);
    pix(3'b001, 3'b000, pack3(24'h000000, 24'h0, 24'h0), "R2 out of range");

    // R9: same-cycle write and lookup of ch1 red 9 (index 777)
    set_index(777, 0);
    cyc(1, 3'b010, 3'b010, pack3(24'h0, 24'h090000, 24'h0), 1, 1, 32'h0000_00E7, "R9 old value");
    pix(3'b010, 3'b000, pack3(24'h0, 24'h090000, 24'h0), "R9 new value");

    // R8: power down, discarded write, entries read 0 afterwards
    set_index(5, 1);
    set_en(3'b000);
    put(8'h99, 24'h0);
    set_en(3'b111);
    pix(3'b111, 3'b000, pack3(24'h050505, 24'h2C2C2C, 24'hFFFFFF), "R8 contents lost");
    pix(3'b001, 3'b000, pack3(24'h060000, 24'h0, 24'h0), "R8 write dropped, index advanced");
    put(8'h42, 24'h0);
    pix(3'b001, 3'b000, pack3(24'h060000, 24'h0, 24'h0), "R8 reload");

    idle(3);
    check(sb.size() == 0, "R6 scoreboard drained", 72'(sb.size()), 72'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule